// File: doc/BRIEF.md
# Eight-Bit Compare Timer with Output Flip-Flop

An eight-bit up-counter steps on a count-clock enable from an external prescaler, or, in cascade mode, on the carry pulses of a neighbouring timer. It compares its count with a compare register. There are two operating modes. In clear-on-match mode the count returns to zero on the step taken while it equals the compare value. In PWM mode the counter runs freely through 255 and back to 0, and the output pin shows a pulse whose width is the compare value.

Outside PWM mode the pin follows a timer output flip-flop. Software sets or clears that flip-flop through command bits in the control register, and a compare match can invert it. A match sets an interrupt flag, which a mask bit gates onto the interrupt request. Stopping the timer clears the counter and also raises that flag. Software therefore masks the interrupt before it stops the timer, clears the flag, removes the mask and then restarts the timer.

Top module: `tmr8_top`

## Requirements
- R1: After reset, every register reads 00h (address 0 control, 1 compare, 2 counter, 3 status), `tmr_out`, `tmr_oe`, `irq` and `prescaler_run` are 0.
- R2: Control bit 7 (run) = 0 holds the counter at 0, ignores count enables and drives `prescaler_run` low. With run = 1, the counter advances by one on each enabled count step.
- R3: With control bit 6 = 0 (clear-on-match mode), a count step taken while the count equals the compare value sets the count to 0 rather than incrementing it.
- R4: With control bit 6 = 1 (PWM mode), the counter does not clear at the compare value and wraps from 255 to 0.
- R5: In PWM mode the output is active while run = 1 and count < compare, and inactive otherwise (including whenever run = 0). Control bit 1 selects the active level: 0 means active high, 1 means active low.
- R6: With control bit 4 = 1 (cascade), the counter steps only on `cascade_in` pulses and ignores `cnt_tick`. With bit 4 = 0 it steps on `cnt_tick` only.
- R7: Control bits 3 and 2 form a one-shot flip-flop command. 10 sets the flip-flop, 01 clears it, 00 and 11 leave it unchanged, and both bits always read back as 0. Bit 5 reads as 0.
- R8: Outside PWM mode, with control bit 1 = 1, each compare match inverts the output flip-flop. With bit 1 = 0, matches leave it unchanged.
- R9: A set or clear command written in the same cycle as a compare match that would invert the flip-flop takes precedence, and the flip-flop takes the commanded value.
- R10: With control bit 0 = 0, `tmr_oe` is 0 and `tmr_out` is 0. With bit 0 = 1, `tmr_oe` is 1 and `tmr_out` carries the timer output.
- R11: Each compare match sets status bit 0 (flag). Status bit 1 is the mask. `irq` = flag AND NOT mask. A write to address 3 loads both bits, except that a match in the same cycle leaves the flag set.
- R12: A control write that changes run from 1 to 0 sets the flag. With the mask set, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 compare, 2 counter, 3 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cnt_tick | input | 1 | Count enable from the prescaler |
| cascade_in | input | 1 | Carry pulse from the neighbouring timer |
| prescaler_run | output | 1 | Enables the external prescaler (the run bit) |
| tmr_out | output | 1 | Timer output pin value |
| tmr_oe | output | 1 | Timer drives the pin |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first is a software set or clear command and the compare-match inversion of the flip-flop. The second is a status write that clears the flag and a match that sets it. The bench provokes each pair by asserting the count enable and the bus write in the same cycle while the count sits at the compare value. It then checks that the flip-flop takes the command's value instead of the inverted one, and that the flag reads back as 1 while the counter has returned to 0. Active-level selection and the inactive level after stopping are judged at the pin in both polarities.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam int unsigned B_RUN  = 7;
  localparam int unsigned B_PWM  = 6;
  localparam int unsigned B_CASC = 4;
  localparam int unsigned B_SET  = 3;
  localparam int unsigned B_RST  = 2;
  localparam int unsigned B_LVL  = 1;
  localparam int unsigned B_OE   = 0;

  typedef struct packed {
    logic run;
    logic pwm;
    logic casc;
    logic lvl;
    logic oe;
  } ctrl_t;
endpackage

// File: rtl/tmr8_rst_sync.sv
module tmr8_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              match_evt,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmp,
  output logic              cmd_set,
  output logic              cmd_rst,
  output logic              irq
);
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] cmp_d;
  logic             flag_q, flag_d;
  logic             mask_q, mask_d;
  logic             ctrl_we, cmp_we, stat_we, run_fall;
  logic             unused_wbit;

  assign unused_wbit = bus_wdata[5];

  always_comb begin
    ctrl_we  = bus_we && (bus_addr == A_CTRL);
    cmp_we   = bus_we && (bus_addr == A_CMP);
    stat_we  = bus_we && (bus_addr == A_STAT);
    run_fall = ctrl_we && !bus_wdata[B_RUN] && ctrl.run;
    cmd_set  = ctrl_we && bus_wdata[B_SET] && !bus_wdata[B_RST];
    cmd_rst  = ctrl_we && !bus_wdata[B_SET] && bus_wdata[B_RST];

    ctrl_d = ctrl;
    if (ctrl_we) begin
      ctrl_d.run  = bus_wdata[B_RUN];
      ctrl_d.pwm  = bus_wdata[B_PWM];
      ctrl_d.casc = bus_wdata[B_CASC];
      ctrl_d.lvl  = bus_wdata[B_LVL];
      ctrl_d.oe   = bus_wdata[B_OE];
    end

    cmp_d = cmp_we ? bus_wdata[CNT_W-1:0] : cmp;

    if (match_evt || run_fall) flag_d = 1'b1;
    else if (stat_we)          flag_d = bus_wdata[0];
    else                       flag_d = flag_q;

    mask_d = stat_we ? bus_wdata[1] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cmp    <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      ctrl   <= ctrl_d;
      cmp    <= cmp_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign irq = flag_q && !mask_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_RUN]  = ctrl.run;
        bus_rdata[B_PWM]  = ctrl.pwm;
        bus_rdata[B_CASC] = ctrl.casc;
        bus_rdata[B_LVL]  = ctrl.lvl;
        bus_rdata[B_OE]   = ctrl.oe;
      end
      A_CMP:   bus_rdata[CNT_W-1:0] = cmp;
      A_CNT:   bus_rdata[CNT_W-1:0] = cnt;
      default: bus_rdata[1:0] = {mask_q, flag_q};
    endcase
  end

  p_match_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (bus_addr != A_STAT) || bus_rdata[0]);
  p_mask_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && bus_wdata[1] && !match_evt && !run_fall) |=> !irq);
  p_runfall_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    run_fall |=> (flag_q && !ctrl.run));
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwm,
  input  logic             casc,
  input  logic             tick,
  input  logic             carry,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             count_en;
  logic             at_cmp;

  always_comb begin
    count_en  = run && (casc ? carry : tick);
    at_cmp    = (cnt == cmp);
    match_evt = count_en && at_cmp;
    if (!run)                    cnt_d = '0;
    else if (!count_en)          cnt_d = cnt;
    else if (!pwm && at_cmp)     cnt_d = '0;
    else                         cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !(at_cmp && !pwm)) |=> (cnt == $past(cnt) + 1'b1));
  p_clear_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !pwm) |=> (cnt == '0));
  p_pwm_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && count_en && (cnt == {CNT_W{1'b1}})) |=> (cnt == '0));
  p_casc_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && casc && !carry) |=> $stable(cnt));
endmodule

// File: rtl/tmr8_outff.sv
module tmr8_outff
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             cmd_set,
  input  logic             cmd_rst,
  input  logic             match_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pin_out,
  output logic             pin_oe
);
  logic ff_q, ff_d;
  logic toggle;
  logic pwm_act;
  logic drive;

  always_comb begin
    toggle = match_evt && ctrl.lvl && !ctrl.pwm;
    if (cmd_set)      ff_d = 1'b1;
    else if (cmd_rst) ff_d = 1'b0;
    else if (toggle)  ff_d = !ff_q;
    else              ff_d = ff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= ff_d;
  end

  always_comb begin
    pwm_act = ctrl.run && (cnt < cmp);
    drive   = ctrl.pwm ? (pwm_act ^ ctrl.lvl) : ff_q;
    pin_out = ctrl.oe && drive;
    pin_oe  = ctrl.oe;
  end

  p_cmd_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> ff_q);
  p_cmd_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> !ff_q);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_set && !cmd_rst && !toggle) |=> $stable(ff_q));
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !cmd_set && !cmd_rst) |=> (ff_q != $past(ff_q)));
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
  import tmr8_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              cnt_tick,
  input  logic              cascade_in,
  output logic              prescaler_run,
  output logic              tmr_out,
  output logic              tmr_oe,
  output logic              irq
);
  localparam int unsigned CNT_W = BUS_W;

  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] cnt;
  logic             match_evt;
  logic             cmd_set, cmd_rst;

  tmr8_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tmr8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .match_evt(match_evt), .cnt(cnt),
    .ctrl(ctrl), .cmp(cmp), .cmd_set(cmd_set), .cmd_rst(cmd_rst),
    .irq(irq)
  );

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .run(ctrl.run), .pwm(ctrl.pwm), .casc(ctrl.casc),
    .tick(cnt_tick), .carry(cascade_in), .cmp(cmp),
    .cnt(cnt), .match_evt(match_evt)
  );

  tmr8_outff #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .ctrl(ctrl),
    .cmd_set(cmd_set), .cmd_rst(cmd_rst), .match_evt(match_evt),
    .cnt(cnt), .cmp(cmp), .pin_out(tmr_out), .pin_oe(tmr_oe)
  );

  assign prescaler_run = ctrl.run;

  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tmr_oe |-> !tmr_out);
  p_pwm_idle_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.pwm && !prescaler_run && tmr_oe) |-> (tmr_out == ctrl.lvl));
endmodule

// File: tb/tmr8_top_tb.sv
module tmr8_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cnt_tick = 1'b0;
  logic       cascade_in = 1'b0;
  logic       prescaler_run, tmr_out, tmr_oe, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr8_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
    .cascade_in(cascade_in), .prescaler_run(prescaler_run),
    .tmr_out(tmr_out), .tmr_oe(tmr_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_tick = 1'b1;
      @(negedge clk); cnt_tick = 1'b0;
    end
  endtask

  task automatic carries(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cascade_in = 1'b1;
      @(negedge clk); cascade_in = 1'b0;
    end
  endtask

  task automatic step_and_write(input bit use_carry, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (use_carry) cascade_in = 1'b1; else cnt_tick = 1'b1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    cascade_in = 1'b0; cnt_tick = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 cmp", v, 8'h00);
    rd(2'd2, v); chk("R1 cnt", v, 8'h00);
    rd(2'd3, v); chk("R1 stat", v, 8'h00);
    chk("R1 pins", {4'd0, prescaler_run, tmr_out, tmr_oe, irq}, 8'h00);
  endtask

  task automatic t_clear_mode();
    logic [7:0] v;
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h80);
    chk("R2 prescaler_run", {7'd0, prescaler_run}, 8'h01);
    ticks(3);
    rd(2'd2, v); chk("R2 count", v, 8'd3);
    rd(2'd3, v); chk("R11 no flag before match", v, 8'h00);
    ticks(1);
    rd(2'd2, v); chk("R3 clear on match", v, 8'd0);
    rd(2'd3, v); chk("R11 flag on match", v, 8'h01);
    chk("R11 irq", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h00);
    chk("R11 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    ticks(2);
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h00);
    rd(2'd3, v); chk("R12 stop sets flag", v, 8'h03);
    chk("R12 masked irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rd(2'd2, v); chk("R2 cleared on stop", v, 8'd0);
    chk("R2 prescaler off", {7'd0, prescaler_run}, 8'h00);
    ticks(3);
    rd(2'd2, v); chk("R2 ticks ignored stopped", v, 8'd0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    wr(2'd1, 8'd2);
    wr(2'd0, 8'hC1);
    chk("R5 active high cnt0", {7'd0, tmr_out}, 8'h01);
    ticks(1);
    chk("R5 active cnt1", {7'd0, tmr_out}, 8'h01);
    ticks(1);
    chk("R5 inactive at cmp", {7'd0, tmr_out}, 8'h00);
    ticks(1);
    rd(2'd2, v); chk("R4 no clear at cmp", v, 8'd3);
    ticks(253);
    rd(2'd2, v); chk("R4 wrap", v, 8'd0);
    chk("R5 active after wrap", {7'd0, tmr_out}, 8'h01);
    wr(2'd0, 8'hC3);
    chk("R5 active low", {7'd0, tmr_out}, 8'h00);
    wr(2'd0, 8'h43);
    chk("R5 stopped low-active idle", {7'd0, tmr_out}, 8'h01);
    wr(2'd0, 8'h41);
    chk("R5 stopped high-active idle", {7'd0, tmr_out}, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_cmds();
    logic [7:0] v;
    wr(2'd0, 8'h09);
    chk("R7 set", {7'd0, tmr_out}, 8'h01);
    rd(2'd0, v); chk("R7 cmd bits read 0", v, 8'h01);
    wr(2'd0, 8'h0D);
    chk("R7 code 11 keeps 1", {7'd0, tmr_out}, 8'h01);
    wr(2'd0, 8'h05);
    chk("R7 reset", {7'd0, tmr_out}, 8'h00);
    wr(2'd0, 8'h0D);
    chk("R7 code 11 keeps 0", {7'd0, tmr_out}, 8'h00);
    wr(2'd0, 8'h2C);
    rd(2'd0, v); chk("R7 bit5 and cmd read 0", v, 8'h00);
  endtask

  task automatic t_toggle();
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h83);
    ticks(1);
    chk("R8 no toggle before match", {7'd0, tmr_out}, 8'h00);
    ticks(1);
    chk("R8 toggle to 1", {7'd0, tmr_out}, 8'h01);
    ticks(2);
    chk("R8 toggle to 0", {7'd0, tmr_out}, 8'h00);
    wr(2'd0, 8'h89);
    ticks(2);
    chk("R8 inversion off holds", {7'd0, tmr_out}, 8'h01);
    wr(2'd0, 8'h85);
    chk("R10 output driven", {7'd0, tmr_oe}, 8'h01);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h83);
    ticks(1);
    step_and_write(1'b0, 2'd0, 8'h87);
    chk("R9 reset beats toggle", {7'd0, tmr_out}, 8'h00);
    rd(2'd3, v); chk("R9 match still flagged", v, 8'h01);
    ticks(2);
    chk("R8 toggle after collision", {7'd0, tmr_out}, 8'h01);
    ticks(1);
    step_and_write(1'b0, 2'd0, 8'h8B);
    chk("R9 set beats toggle", {7'd0, tmr_out}, 8'h01);
  endtask

  task automatic t_cascade();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h90);
    ticks(3);
    rd(2'd2, v); chk("R6 tick ignored in cascade", v, 8'd0);
    carries(2);
    rd(2'd2, v); chk("R6 carry counts", v, 8'd2);
    carries(3);
    wr(2'd3, 8'h00);
    step_and_write(1'b1, 2'd3, 8'h00);
    rd(2'd3, v); chk("R11 match wins over clear", v, 8'h01);
    rd(2'd2, v); chk("R3 cascade clear", v, 8'd0);
    wr(2'd0, 8'h00);
    carries(2);
    wr(2'd0, 8'h80);
    carries(2);
    rd(2'd2, v); chk("R6 carry ignored single", v, 8'd0);
  endtask

  task automatic t_oe_irq();
    logic [7:0] v;
    wr(2'd0, 8'h08);
    chk("R10 oe off", {6'd0, tmr_oe, tmr_out}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R10 oe on", {6'd0, tmr_oe, tmr_out}, 8'h03);
    wr(2'd3, 8'h03);
    chk("R11 masked", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h01);
    chk("R11 unmasked", {7'd0, irq}, 8'h01);
    rd(2'd3, v); chk("R11 status", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clear_mode();
    t_stop();
    t_pwm();
    t_cmds();
    t_toggle();
    t_collide();
    t_cascade();
    t_oe_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule